// File: doc/BRIEF.md
# DAC Trigger and Data Controller

This block is the digital front end of a 12-bit digital-to-analog converter. Software, or a DMA engine, programs it through a small word-wide register port with four registers: control, data holding, software trigger and status. The block decides when a conversion starts, takes the 12-bit code out of the held data word with the programmed alignment, and presents that code to the converter. It then reports busy and finish, and raises an interrupt when enabled.

A conversion can start in one of three ways. The first is a plain write of the data register. The second is a software pulse. The third is a hardware event: an external pin condition (low level, high level, falling edge or rising edge), one of four timer pulses, or one of two PWM pulses. When DMA is enabled, each accepted hardware event asks for the next data word. If another accepted hardware event arrives before that word has been written, the block records an under-run and converts the code it already holds again. The analog converter is modelled by a busy window of a fixed, parameterised number of clocks.

Top module: `dac_trig_ctrl`

## Requirements
- R1: The register addresses are 0 = control, 1 = data holding, 2 = software trigger, 3 = status. The control fields are: bit 0 trigger enable, bit 1 left alignment, bit 2 DMA enable, bit 3 finish interrupt enable, bit 4 under-run interrupt enable, bits 7:5 source select, bits 9:8 pin condition. Control and data registers read back what was written.
- R2: With trigger enable set, the source select decodes as 0 = software, 1 = external pin, 2..5 = timer pulse 0..3, 6 = PWM pulse 0 and 7 = PWM pulse 1. Pulses on sources that are not selected start nothing.
- R3: With trigger enable cleared, a data-register write starts a conversion of the newly written word. With trigger enable set, a data write only updates the held word.
- R4: Writing 1 to bit 0 of the software trigger register starts a conversion only when trigger enable is set and the source select is 0. The software trigger register always reads 0.
- R5: The pin passes through a two-stage synchronizer. Pin conditions are 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge. An edge is found by comparing the current and previous synchronized samples.
- R6: With right alignment the code is held data bits 11:0. With left alignment it is bits 15:4. All other bits have no effect on the code.
- R7: Busy rises on the cycle after a trigger is accepted and stays high for exactly BUSY_CYC clocks. The finish flag is set as busy falls.
- R8: Status reads finish in bit 0, under-run in bit 1 and busy in bit 8. Writing 1 to bit 0 or bit 1 of status clears that flag.
- R9: The irq output is high while (finish and finish interrupt enable) or (under-run and under-run interrupt enable).
- R10: An accepted hardware trigger with DMA enable set drives dma_req high. It stays high until the next data-register write.
- R11: An accepted hardware trigger while dma_req is still high sets under-run and converts the held code again.
- R12: Triggers arriving while busy are ignored: the code does not change and no DMA request is made.
- R13: After reset the code, the control register, the held data, status, busy, dma_req and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| tmr_pulse | input | 4 | Single-cycle timer trigger pulses |
| pwm_pulse | input | 2 | Single-cycle PWM trigger pulses |
| dac_code | output | 12 | Code presented to the converter |
| busy | output | 1 | Conversion in progress |
| dma_req | output | 1 | Request for the next data word |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume that timer and PWM pulses are synchronous to clk and that only the pin input is asynchronous. They also assume that a DMA answer always arrives as a data-register write. The bench drives every input away from the active edge, holds each pulse for a single cycle, and only changes control while the block is idle or where the test intends a change. It waits out the synchronizer and busy windows before each sample, so every checked value is settled.

// File: rtl/dac_tc_pkg.sv
`timescale 1ns/1ps
package dac_tc_pkg;
  localparam int CODE_W   = 12;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2;
  localparam int LEFT_LSB = 4;
  localparam int N_TMR    = 4;
  localparam int N_PWM    = 2;
  localparam int N_SRC    = 2 + N_TMR + N_PWM;
  localparam int SEL_W    = $clog2(N_SRC);
  localparam int FIN_BIT  = 0;
  localparam int UDR_BIT  = 1;
  localparam int BUSY_BIT = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTL  = 2'd0,
    A_DAT  = 2'd1,
    A_SWT  = 2'd2,
    A_STAT = 2'd3
  } addr_e;

  typedef enum logic [1:0] {
    PIN_LOW  = 2'd0,
    PIN_HIGH = 2'd1,
    PIN_FALL = 2'd2,
    PIN_RISE = 2'd3
  } pin_mode_e;

  // Packed MSB first: bit 0 is trg_en.
  typedef struct packed {
    pin_mode_e        pin_mode;  // 9:8
    logic [SEL_W-1:0] src_sel;   // 7:5
    logic             udr_ien;   // 4
    logic             fin_ien;   // 3
    logic             dma_en;    // 2
    logic             left_al;   // 1
    logic             trg_en;    // 0
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/dac_pin_cond.sv
`timescale 1ns/1ps
module dac_pin_cond
  import dac_tc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_q,
  input  logic      pin,
  input  pin_mode_e mode,
  output logic      evt
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   cur;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign cur = sync_q[SYNC_STAGES-1];

  always_comb begin
    unique case (mode)
      PIN_LOW:  evt = ~cur;
      PIN_HIGH: evt = cur;
      PIN_FALL: evt = prev_q & ~cur;
      PIN_RISE: evt = ~prev_q & cur;
      default:  evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/dac_trig_sel.sv
`timescale 1ns/1ps
module dac_trig_sel
  import dac_tc_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             pin_evt,
  input  logic [N_TMR-1:0] tmr,
  input  logic [N_PWM-1:0] pwm,
  output logic             hw_evt
);
  logic [N_SRC-1:0] src_vec;

  // Slot 0 is the software source, which is not a hardware event.
  assign src_vec = {pwm, tmr, pin_evt, 1'b0};
  assign hw_evt  = src_vec[sel];
endmodule

// File: rtl/dac_conv_timer.sv
`timescale 1ns/1ps
module dac_conv_timer #(
  parameter int BUSY_CYC = 8
) (
  input  logic clk,
  input  logic rst_q,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start | (cnt_q != '0);
    cnt_d  = start ? CNT_W'(BUSY_CYC) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dac_trig_ctrl.sv
`timescale 1ns/1ps
module dac_trig_ctrl
  import dac_tc_pkg::*;
#(
  parameter int BUSY_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ext_pin,
  input  logic [N_TMR-1:0]  tmr_pulse,
  input  logic [N_PWM-1:0]  pwm_pulse,
  output logic [CODE_W-1:0] dac_code,
  output logic              busy,
  output logic              dma_req,
  output logic              irq
);
  // Reset: asserted asynchronously, released on clk.
  logic [1:0] rst_pipe_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q = rst_pipe_q[1];

  ctl_t              ctl_q, ctl_d;
  logic [REG_W-1:0]  hold_q, hold_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              fin_q, fin_d, udr_q, udr_d, dma_q, dma_d;
  logic              ctl_en, hold_en, code_en;

  logic              wr_ctl, wr_dat, wr_swt, wr_stat;
  logic              pin_evt, hw_evt, conv_done;
  logic              start_data, start_sw, start_hw, accept, acc_hw;
  logic [REG_W-1:0]  conv_src;

  dac_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_q(rst_q), .pin(ext_pin),
    .mode(ctl_q.pin_mode), .evt(pin_evt)
  );

  dac_trig_sel u_sel (
    .sel(ctl_q.src_sel), .pin_evt(pin_evt),
    .tmr(tmr_pulse), .pwm(pwm_pulse), .hw_evt(hw_evt)
  );

  dac_conv_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
    .clk(clk), .rst_q(rst_q), .start(accept),
    .busy(busy), .done(conv_done)
  );

  // Bus decode
  always_comb begin
    wr_ctl  = bus_we & (bus_addr == A_CTL);
    wr_dat  = bus_we & (bus_addr == A_DAT);
    wr_swt  = bus_we & (bus_addr == A_SWT) & bus_wdata[0];
    wr_stat = bus_we & (bus_addr == A_STAT);
  end

  // Trigger qualification
  always_comb begin
    start_data = wr_dat & ~ctl_q.trg_en;
    start_sw   = wr_swt & ctl_q.trg_en & (ctl_q.src_sel == '0);
    start_hw   = hw_evt & ctl_q.trg_en & (ctl_q.src_sel != '0);
    accept     = ~busy & (start_data | start_sw | start_hw);
    acc_hw     = ~busy & start_hw;
    conv_src   = wr_dat ? bus_wdata : hold_q;
  end

  // Next state
  always_comb begin
    ctl_d  = ctl_t'(bus_wdata[CTL_W-1:0]);
    hold_d = bus_wdata;
    code_d = ctl_q.left_al ? conv_src[LEFT_LSB +: CODE_W] : conv_src[0 +: CODE_W];
    fin_d  = fin_q;
    udr_d  = udr_q;
    dma_d  = dma_q;
    if (wr_stat && bus_wdata[FIN_BIT]) fin_d = 1'b0;
    if (wr_stat && bus_wdata[UDR_BIT]) udr_d = 1'b0;
    if (conv_done)                     fin_d = 1'b1;
    if (wr_dat)                        dma_d = 1'b0;
    if (acc_hw && ctl_q.dma_en) begin
      if (dma_q && !wr_dat) udr_d = 1'b1;
      dma_d = 1'b1;
    end
    ctl_en  = wr_ctl;
    hold_en = wr_dat;
    code_en = accept;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ctl_q  <= '0;
      hold_q <= '0;
      code_q <= '0;
      fin_q  <= 1'b0;
      udr_q  <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      if (ctl_en)  ctl_q  <= ctl_d;
      if (hold_en) hold_q <= hold_d;
      if (code_en) code_q <= code_d;
      fin_q <= fin_d;
      udr_q <= udr_d;
      dma_q <= dma_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTL:  bus_rdata[CTL_W-1:0] = ctl_q;
      A_DAT:  bus_rdata = hold_q;
      A_SWT:  bus_rdata = '0;
      A_STAT: begin
        bus_rdata[FIN_BIT]  = fin_q;
        bus_rdata[UDR_BIT]  = udr_q;
        bus_rdata[BUSY_BIT] = busy;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign dac_code = code_q;
  assign dma_req  = dma_q;
  assign irq      = (fin_q & ctl_q.fin_ien) | (udr_q & ctl_q.udr_ien);
endmodule

// File: rtl/dac_trig_ctrl_chk.sv
`timescale 1ns/1ps
module dac_trig_ctrl_chk
  import dac_tc_pkg::*;
(
  input logic              clk,
  input logic              rst_q,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [CODE_W-1:0] dac_code,
  input logic              busy,
  input logic              dma_req,
  input logic              irq,
  input logic              fin_q,
  input logic              udr_q,
  input logic              dma_en
);
  // R4
  swt_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_addr == A_SWT) |-> (bus_rdata == '0));

  // R7
  fin_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(busy) |-> fin_q);

  // R8
  stat_busy_bit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_addr == A_STAT) |-> (bus_rdata[BUSY_BIT] == busy));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_q)
    irq |-> (fin_q | udr_q));

  // R10
  dma_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(dma_req) |-> $past(dma_en));

  // R11
  udr_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(udr_q) |-> $past(dma_req));

  // R12
  busy_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    busy |=> $stable(dac_code));

  // R7
  code_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(dac_code) |-> busy);
endmodule

bind dac_trig_ctrl dac_trig_ctrl_chk u_chk (
  .clk(clk), .rst_q(rst_q), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .dac_code(dac_code), .busy(busy), .dma_req(dma_req), .irq(irq),
  .fin_q(fin_q), .udr_q(udr_q), .dma_en(ctl_q.dma_en)
);

// File: tb/dac_trig_ctrl_tb.sv
`timescale 1ns/1ps
module dac_trig_ctrl_tb;
  localparam int BUSY_CYC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_pin = 1'b0;
  logic [3:0]  tmr_pulse = '0;
  logic [1:0]  pwm_pulse = '0;
  logic [11:0] dac_code;
  logic        busy, dma_req, irq;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dac_trig_ctrl #(.BUSY_CYC(BUSY_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
    .tmr_pulse(tmr_pulse), .pwm_pulse(pwm_pulse), .dac_code(dac_code),
    .busy(busy), .dma_req(dma_req), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tmr(input int i);
    @(negedge clk); tmr_pulse[i] = 1'b1;
    @(negedge clk); tmr_pulse = '0;
  endtask

  task automatic pulse_pwm(input int i);
    @(negedge clk); pwm_pulse[i] = 1'b1;
    @(negedge clk); pwm_pulse = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R13 code", {20'd0, dac_code}, 32'd0);
    check("R13 busy", {31'd0, busy}, 32'd0);
    check("R13 dma", {31'd0, dma_req}, 32'd0);
    check("R13 irq", {31'd0, irq}, 32'd0);
    rd(2'd3, v); check("R13 status", v, 32'd0);
    rd(2'd0, v); check("R13 ctl", v, 32'd0);
    rd(2'd1, v); check("R13 hold", v, 32'd0);
  endtask

  task automatic t_direct_write;
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FABC);
    check("R3 direct write code", {20'd0, dac_code}, 32'hABC);
    check("R6 right align", {20'd0, dac_code}, 32'hABC);
    check("R7 busy up", {31'd0, busy}, 32'd1);
    rd(2'd1, v); check("R1 hold readback", v, 32'hFFFF_FABC);
    cycles(BUSY_CYC - 1);
    check("R7 busy still high", {31'd0, busy}, 32'd1);
    cycles(1);
    check("R7 busy fell", {31'd0, busy}, 32'd0);
    rd(2'd3, v); check("R8 finish bit0", v, 32'h1);
    check("R9 irq masked", {31'd0, irq}, 32'd0);
    wr(2'd3, 32'h1);
    rd(2'd3, v); check("R8 finish cleared", v, 32'h0);
  endtask

  task automatic t_left_align;
    logic [31:0] v;
    wr(2'd0, 32'h2);
    rd(2'd0, v); check("R1 ctl readback", v, 32'h2);
    wr(2'd1, 32'h1234_5678);
    check("R6 left align", {20'd0, dac_code}, 32'h567);
    cycles(BUSY_CYC);
  endtask

  task automatic t_software;
    logic [31:0] v;
    wr(2'd3, 32'h3);
    wr(2'd0, 32'h9);
    wr(2'd1, 32'h111);
    check("R3 write with trg_en no start", {31'd0, busy}, 32'd0);
    check("R3 code unchanged", {20'd0, dac_code}, 32'h567);
    wr(2'd2, 32'h1);
    check("R4 sw trigger code", {20'd0, dac_code}, 32'h111);
    check("R4 sw trigger busy", {31'd0, busy}, 32'd1);
    rd(2'd2, v); check("R4 swtrg reads 0", v, 32'd0);
    cycles(BUSY_CYC);
    check("R9 irq on finish", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'h1);
    check("R9 irq cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_timer_pwm;
    wr(2'd0, 32'h61);
    wr(2'd1, 32'h0F0);
    wr(2'd2, 32'h1);
    check("R4 sw ignored when sel!=0", {31'd0, busy}, 32'd0);
    pulse_tmr(0);
    check("R2 unselected timer", {31'd0, busy}, 32'd0);
    pulse_tmr(1);
    check("R2 timer1 starts", {31'd0, busy}, 32'd1);
    check("R2 timer1 code", {20'd0, dac_code}, 32'h0F0);
    check("R10 no dma without enable", {31'd0, dma_req}, 32'd0);
    cycles(BUSY_CYC);
    wr(2'd0, 32'hE1);
    wr(2'd1, 32'h0AB);
    pulse_pwm(0);
    check("R2 unselected pwm", {31'd0, busy}, 32'd0);
    pulse_pwm(1);
    check("R2 pwm1 starts", {31'd0, busy}, 32'd1);
    check("R2 pwm1 code", {20'd0, dac_code}, 32'h0AB);
    cycles(BUSY_CYC);
  endtask

  task automatic t_pin;
    wr(2'd1, 32'h2AA);
    wr(2'd0, 32'h321);
    cycles(4);
    check("R5 rise: low pin idle", {31'd0, busy}, 32'd0);
    ext_pin = 1'b1;
    cycles(4);
    check("R5 rising edge starts", {31'd0, busy}, 32'd1);
    check("R5 rising code", {20'd0, dac_code}, 32'h2AA);
    cycles(BUSY_CYC + 2);
    wr(2'd0, 32'h221);
    cycles(4);
    check("R5 fall: high pin idle", {31'd0, busy}, 32'd0);
    ext_pin = 1'b0;
    cycles(4);
    check("R5 falling edge starts", {31'd0, busy}, 32'd1);
    cycles(BUSY_CYC + 2);
    wr(2'd0, 32'h121);
    cycles(4);
    check("R5 high level: low pin idle", {31'd0, busy}, 32'd0);
    ext_pin = 1'b1;
    cycles(4);
    check("R5 high level starts", {31'd0, busy}, 32'd1);
    ext_pin = 1'b0;
    cycles(2 * BUSY_CYC + 4);
    wr(2'd0, 32'h021);
    cycles(4);
    check("R5 low level starts", {31'd0, busy}, 32'd1);
    wr(2'd0, 32'h0);
    cycles(2 * BUSY_CYC + 4);
    check("R5 low level stopped", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_dma;
    logic [31:0] v;
    wr(2'd3, 32'h3);
    wr(2'd0, 32'h55);
    wr(2'd1, 32'h321);
    check("R10 no request before trigger", {31'd0, dma_req}, 32'd0);
    pulse_tmr(0);
    check("R10 request raised", {31'd0, dma_req}, 32'd1);
    check("R10 code", {20'd0, dac_code}, 32'h321);
    wr(2'd1, 32'h654);
    check("R10 request answered", {31'd0, dma_req}, 32'd0);
    pulse_tmr(0);
    check("R12 busy trigger no request", {31'd0, dma_req}, 32'd0);
    check("R12 busy trigger code kept", {20'd0, dac_code}, 32'h321);
    cycles(BUSY_CYC);
    pulse_tmr(0);
    check("R10 second request", {31'd0, dma_req}, 32'd1);
    check("R10 second code", {20'd0, dac_code}, 32'h654);
    cycles(BUSY_CYC);
    rd(2'd3, v); check("R11 no underrun yet", v & 32'h2, 32'h0);
    pulse_tmr(0);
    rd(2'd3, v); check("R11 underrun set", v & 32'h2, 32'h2);
    check("R11 held code reconverted", {20'd0, dac_code}, 32'h654);
    check("R11 busy on reconvert", {31'd0, busy}, 32'd1);
    check("R9 irq on underrun", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'h2);
    rd(2'd3, v); check("R8 underrun cleared", v & 32'h2, 32'h0);
    check("R9 irq after clear", {31'd0, irq}, 32'd0);
    cycles(BUSY_CYC);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_direct_write();
    t_left_align();
    wr(2'd0, 32'h0);
    t_software();
    t_timer_pwm();
    t_pin();
    t_dma();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule